// File: doc/BRIEF.md
# Indexed Register Port Interface

This block is the slave side of a narrow host bus that reaches a peripheral's register file through two locations: an index port and a data port, both 16 bits wide. The host first loads a register index through the index port. It then moves the register contents through the data port.

Bit 7 of the index byte chooses the direction of the data access that follows. Indices below 0x20 name 32-bit registers, which travel as two data cycles with the low half first. Higher indices name 16-bit registers, which need only one data cycle.

The register file holds the following:
- an identification word;
- a scratch word;
- a keyed software reset;
- a functional-state field, whose value is driven out;
- a host-reset request, which gives a one-cycle pulse;
- sticky event flags with a set/clear enable mask, which together drive an interrupt line;
- a read-only view of buffer status flags.

A small sequencer with three states tracks the access. The states are IDLE (no access pending), LOW (waiting for the only or first data cycle) and HIGH (waiting for the second half of a 32-bit access). The transitions are:
- index load: any state to LOW, on an index-port strobe;
- narrow finish: LOW to IDLE, on a data cycle to a 16-bit index;
- wide step: LOW to HIGH, on a data cycle to a 32-bit index;
- wide finish: HIGH to IDLE, on the second data cycle.

Top module: `idx_reg_port`

## Requirements
- R1: An index-port strobe keeps `wdata_i[7:0]` and ignores the upper byte. Bit 7 set marks the access as a write and bit 7 clear marks it as a read; bits 6:0 are the index. The strobe always restarts the access at its first data cycle and abandons any half-done 32-bit access without writing it.
- R2: An index below 0x20 is a 32-bit register and takes two data cycles, low half first. A 32-bit write changes the register only at the clock edge of the second cycle. A 32-bit read returns, in its second cycle, the high half as it stood at the first cycle.
- R3: An index of 0x20 or above is a 16-bit register and completes in one data cycle. A write takes effect at that cycle's clock edge.
- R4: When no access is pending, a data cycle is ignored and `rdata_o` is 0. An index strobe and a data strobe in the same cycle act as the index strobe alone. `rdata_o` is 0 in any cycle that is not a read data cycle.
- R5: Index 0x27 is read-only and returns `CHIP_ID`, whose default is 0x6123 (upper byte 0x61).
- R6: Index 0x28 is a 16-bit scratch word: what is written is read back.
- R7: Writing 0x00F6 to index 0x29 clears the scratch word, the state field, the enable mask and the event flags. Any other value written there has no effect. Index 0x29 reads 0.
- R8: Index 0x01 holds a 2-bit functional state in bits 7:6 (0 reset, 1 resume, 2 operational, 3 suspend). The state is driven on `fstate_o`. All other bits of index 0x01 read 0.
- R9: Writing index 0x02 with bit 0 set raises `hc_reset_o` for exactly the one cycle after the write's final edge. Index 0x02 reads 0.
- R10: Index 0x03 reads the event flags in bits 6:0. A flag is set at any edge where its `evt_i` bit is 1. Writing a 1 clears a flag, unless that flag's event arrives at the same edge, in which case the flag stays set.
- R11: Writing 1s to index 0x04 sets enable-mask bits, and writing 1s to index 0x05 clears them; 0 bits leave the mask alone. Both indices read the mask. `irq_o` is 1 when any flag has its mask bit set.
- R12: Index 0x2C reads `buf_i` zero-extended; writes to it have no effect.
- R13: An index not listed above reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ap_stb_i | input | 1 | Index-port strobe, one per cycle |
| dp_stb_i | input | 1 | Data-port strobe, one per cycle |
| wdata_i | input | 16 | Write data for either port |
| rdata_o | output | 16 | Read data, valid during a read data cycle |
| evt_i | input | NUM_EVT (7) | Event pulses that set the flags |
| buf_i | input | BUF_W (6) | Buffer status flags |
| fstate_o | output | 2 | Functional state field |
| hc_reset_o | output | 1 | One-cycle host-reset request |
| irq_o | output | 1 | Masked event interrupt |

## Verification
The event-flag register is the place where two functions meet in one cycle: an event arriving from `evt_i` and a host write that clears the same flag. The bench provokes this by holding the event bit high during the second data cycle of a clear write to index 0x03. It judges the result by reading the flags back afterwards: the flag must still be set. A second clear write, this time without the event, must then leave the flag at 0. A second collision also gets its own check: an index strobe and a data strobe in the same cycle, where the scratch word must show that the data strobe was dropped.

// File: rtl/idxp_pkg.sv
package idxp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    localparam int          IDX_W      = 7;
    localparam logic [6:0]  IX_WIDE    = 7'h20;
    localparam logic [6:0]  IX_CTRL    = 7'h01;
    localparam logic [6:0]  IX_CMD     = 7'h02;
    localparam logic [6:0]  IX_EVT     = 7'h03;
    localparam logic [6:0]  IX_ENSET   = 7'h04;
    localparam logic [6:0]  IX_ENCLR   = 7'h05;
    localparam logic [6:0]  IX_ID      = 7'h27;
    localparam logic [6:0]  IX_SCR     = 7'h28;
    localparam logic [6:0]  IX_SWRST   = 7'h29;
    localparam logic [6:0]  IX_BUF     = 7'h2C;
    localparam logic [15:0] RST_KEY    = 16'h00F6;
endpackage

// File: rtl/idxp_seq.sv
module idxp_seq
    import idxp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ap_stb,
    input  logic             dp_stb,
    input  logic [15:0]      wdata,
    input  logic [31:0]      rd_val,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en,
    output logic [31:0]      wr_val,
    output logic [15:0]      rdata
);
    phase_t            phase_q;
    logic              wflag_q;
    logic [IDX_W-1:0]  idx_q;
    logic [15:0]       hold_q;
    logic              dcyc;
    logic              wide;

    assign dcyc = dp_stb && !ap_stb;
    assign wide = (idx_q < IX_WIDE);
    assign idx  = idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            wflag_q <= 1'b0;
            idx_q   <= '0;
            hold_q  <= '0;
        end else if (ap_stb) begin
            phase_q <= PH_LOW;
            wflag_q <= wdata[7];
            idx_q   <= wdata[6:0];
        end else if (dcyc) begin
            unique case (phase_q)
                PH_LOW: begin
                    if (wide) begin
                        phase_q <= PH_HIGH;
                        hold_q  <= wflag_q ? wdata : rd_val[31:16];
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_HIGH: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en  = 1'b0;
        wr_val = {16'h0000, wdata};
        rdata  = 16'h0000;
        if (dcyc) begin
            unique case (phase_q)
                PH_LOW: begin
                    wr_en = wflag_q && !wide;
                    if (!wflag_q) rdata = rd_val[15:0];
                end
                PH_HIGH: begin
                    wr_en  = wflag_q;
                    wr_val = {wdata, hold_q};
                    if (!wflag_q) rdata = hold_q;
                end
                default: ;
            endcase
        end
    end

    assert_idx_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ap_stb |=> (phase_q == PH_LOW));
    assert_wide_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dcyc && phase_q == PH_LOW && wide) |=> (phase_q == PH_HIGH));
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (rdata == 16'h0000 && !wr_en));
endmodule

// File: rtl/idxp_regs.sv
module idxp_regs
    import idxp_pkg::*;
#(
    parameter int          NUM_EVT = 7,
    parameter int          BUF_W   = 6,
    parameter logic [15:0] CHIP_ID = 16'h6123
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wr_en,
    input  logic [31:0]        wr_val,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [BUF_W-1:0]   bufst,
    output logic [31:0]        rd_val,
    output logic [1:0]         fstate,
    output logic               hc_reset,
    output logic               irq
);
    localparam int EPAD = 32 - NUM_EVT;
    localparam int BPAD = 32 - BUF_W;

    logic [1:0]         fs_q;
    logic [15:0]        scr_q;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] ev_q;
    logic               pulse_q;
    logic               swrst;
    logic               ev_clr_wr;

    assign swrst     = wr_en && idx == IX_SWRST && wr_val[15:0] == RST_KEY;
    assign ev_clr_wr = wr_en && idx == IX_EVT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q    <= 2'd0;
            scr_q   <= '0;
            en_q    <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wr_en && idx == IX_CMD && wr_val[0];
            if (swrst) begin
                fs_q  <= 2'd0;
                scr_q <= '0;
                en_q  <= '0;
            end else if (wr_en) begin
                if (idx == IX_CTRL)  fs_q  <= wr_val[7:6];
                if (idx == IX_SCR)   scr_q <= wr_val[15:0];
                if (idx == IX_ENSET) en_q  <= en_q | wr_val[NUM_EVT-1:0];
                if (idx == IX_ENCLR) en_q  <= en_q & ~wr_val[NUM_EVT-1:0];
            end
        end
    end

    // one sticky flag per event source; set wins over clear and reset
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ev_q[i] <= 1'b0;
            else if (evt[i])
                ev_q[i] <= 1'b1;
            else if (swrst || (ev_clr_wr && wr_val[i]))
                ev_q[i] <= 1'b0;
        end
    end

    always_comb begin
        unique case (idx)
            IX_CTRL:  rd_val = {24'h0, fs_q, 6'h00};
            IX_EVT:   rd_val = {{EPAD{1'b0}}, ev_q};
            IX_ENSET,
            IX_ENCLR: rd_val = {{EPAD{1'b0}}, en_q};
            IX_ID:    rd_val = {16'h0, CHIP_ID};
            IX_SCR:   rd_val = {16'h0, scr_q};
            IX_BUF:   rd_val = {{BPAD{1'b0}}, bufst};
            default:  rd_val = 32'h0;
        endcase
    end

    assign fstate   = fs_q;
    assign hc_reset = pulse_q;
    assign irq      = |(ev_q & en_q);

    assert_key_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (scr_q == 16'h0 && en_q == '0 && fs_q == 2'd0));
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    assert_evt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ev_q & $past(evt)) == $past(evt)));
    assert_dis_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_ENCLR) |=> ((en_q & $past(wr_val[NUM_EVT-1:0])) == '0));
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
    import idxp_pkg::*;
#(
    parameter int          NUM_EVT = 7,
    parameter int          BUF_W   = 6,
    parameter logic [15:0] CHIP_ID = 16'h6123
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ap_stb_i,
    input  logic               dp_stb_i,
    input  logic [15:0]        wdata_i,
    output logic [15:0]        rdata_o,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [BUF_W-1:0]   buf_i,
    output logic [1:0]         fstate_o,
    output logic               hc_reset_o,
    output logic               irq_o
);
    logic [IDX_W-1:0] idx;
    logic             wr_en;
    logic [31:0]      wr_val;
    logic [31:0]      rd_val;

    idxp_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ap_stb (ap_stb_i),
        .dp_stb (dp_stb_i),
        .wdata  (wdata_i),
        .rd_val (rd_val),
        .idx    (idx),
        .wr_en  (wr_en),
        .wr_val (wr_val),
        .rdata  (rdata_o)
    );

    idxp_regs #(
        .NUM_EVT (NUM_EVT),
        .BUF_W   (BUF_W),
        .CHIP_ID (CHIP_ID)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .wr_en    (wr_en),
        .wr_val   (wr_val),
        .evt      (evt_i),
        .bufst    (buf_i),
        .rd_val   (rd_val),
        .fstate   (fstate_o),
        .hc_reset (hc_reset_o),
        .irq      (irq_o)
    );
endmodule

// File: tb/sim_idx_reg_port.sv
`timescale 1ns/1ps
module sim_idx_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ap_stb = 1'b0;
    logic        dp_stb = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [6:0]  evt = '0;
    logic [5:0]  bufst = '0;
    logic [1:0]  fstate;
    logic        hc_reset;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] r;
    logic [15:0] r2;

    always #4 clk = ~clk;

    idx_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .ap_stb_i(ap_stb), .dp_stb_i(dp_stb),
        .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .buf_i(bufst),
        .fstate_o(fstate), .hc_reset_o(hc_reset), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic aport(input logic [6:0] ix, input logic wr);
        @(negedge clk);
        ap_stb = 1'b1;
        wdata  = {8'hA5, wr, ix};
        @(posedge clk); #1;
        ap_stb = 1'b0;
    endtask

    task automatic dport(input logic [15:0] v, output logic [15:0] rv);
        @(negedge clk);
        dp_stb = 1'b1;
        wdata  = v;
        #1 rv = rdata;
        @(posedge clk); #1;
        dp_stb = 1'b0;
    endtask

    task automatic wr16(input logic [6:0] ix, input logic [15:0] v);
        logic [15:0] d;
        aport(ix, 1'b1); dport(v, d);
    endtask

    task automatic rd16(input logic [6:0] ix, output logic [15:0] v);
        aport(ix, 1'b0); dport(16'h0, v);
    endtask

    task automatic wr32(input logic [6:0] ix, input logic [31:0] v);
        logic [15:0] d;
        aport(ix, 1'b1); dport(v[15:0], d); dport(v[31:16], d);
    endtask

    task automatic rd32(input logic [6:0] ix, output logic [31:0] v);
        logic [15:0] lo, hi;
        aport(ix, 1'b0); dport(16'h0, lo); dport(16'h0, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset;
        check("R4 reset rdata", rdata, 0);
        check("R8 reset fstate", fstate, 0);
        check("R11 reset irq", irq, 0);
        check("R9 reset pulse", hc_reset, 0);
    endtask

    task automatic t_id_scratch;
        logic [15:0] v;
        rd16(7'h27, v); check("R5 chip id", v, 16'h6123);
        wr16(7'h28, 16'hBEEF); rd16(7'h28, v); check("R6 R3 scratch", v, 16'hBEEF);
        wr16(7'h28, 16'h1234); rd16(7'h28, v); check("R6 scratch rewrite", v, 16'h1234);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        logic [15:0] d;
        aport(7'h01, 1'b1); dport(16'h00C0, d);
        check("R2 no effect after low half", fstate, 0);
        dport(16'hFFFF, d);
        check("R8 R2 state suspend", fstate, 3);
        wr32(32'hFFFF_FF80 >> 0 == 0 ? 7'h01 : 7'h01, 32'hFFFF_FF80);
        check("R8 state operational", fstate, 2);
        rd32(7'h01, v); check("R8 other bits zero", v, 32'h0000_0080);
    endtask

    task automatic t_abandon;
        logic [15:0] d, v;
        aport(7'h01, 1'b1); dport(16'h0040, d);
        wr16(7'h28, 16'h5A5A);
        check("R1 abandoned wide write", fstate, 2);
        rd16(7'h28, v); check("R1 new access done", v, 16'h5A5A);
    endtask

    task automatic t_idle_and_collide;
        logic [15:0] d, v;
        rd16(7'h28, v);
        dport(16'h0, d); check("R4 idle read zero", d, 0);
        dport(16'h7777, d);
        aport(7'h28, 1'b1);
        @(negedge clk); ap_stb = 1'b1; dp_stb = 1'b1; wdata = 16'h00A8;
        @(posedge clk); #1; ap_stb = 1'b0; dp_stb = 1'b0;
        rd16(7'h28, v); check("R4 idle write and collision ignored", v, 16'h5A5A);
    endtask

    task automatic t_cmd;
        logic [31:0] v;
        wr32(7'h02, 32'h1);
        check("R9 pulse high", hc_reset, 1);
        @(posedge clk); #1;
        check("R9 pulse one cycle", hc_reset, 0);
        rd32(7'h02, v); check("R9 reads zero", v, 0);
    endtask

    task automatic t_events;
        logic [31:0] v;
        logic [15:0] d;
        @(negedge clk); evt = 7'h04; @(posedge clk); #1; evt = 7'h00;
        rd32(7'h03, v); check("R10 flag set", v, 32'h4);
        aport(7'h03, 1'b1); dport(16'h0004, d);
        @(negedge clk); dp_stb = 1'b1; wdata = 16'h0; evt = 7'h04;
        @(posedge clk); #1; dp_stb = 1'b0; evt = 7'h00;
        rd32(7'h03, v); check("R10 set wins over clear", v, 32'h4);
        wr32(7'h04, 32'h14); rd32(7'h04, v); check("R11 mask set", v, 32'h14);
        check("R11 irq asserted", irq, 1);
        wr32(7'h05, 32'h04); rd32(7'h05, v); check("R11 mask cleared", v, 32'h10);
        check("R11 irq dropped", irq, 0);
        wr32(7'h03, 32'h4); rd32(7'h03, v); check("R10 flag cleared", v, 0);
    endtask

    task automatic t_misc;
        logic [15:0] v;
        logic [31:0] w;
        bufst = 6'h2A;
        rd16(7'h2C, v); check("R12 buffer status", v, 16'h002A);
        wr16(7'h2C, 16'hFFFF); rd16(7'h2C, v); check("R12 write ignored", v, 16'h002A);
        rd16(7'h30, v); check("R13 unimplemented reads zero", v, 0);
        wr16(7'h30, 16'hFFFF); rd16(7'h28, v); check("R13 write no effect", v, 16'h5A5A);
        rd32(7'h10, w); check("R13 wide unimplemented zero", w, 0);
    endtask

    task automatic t_swrst;
        logic [15:0] v;
        logic [31:0] w;
        wr16(7'h29, 16'h0011); rd16(7'h28, v); check("R7 wrong key ignored", v, 16'h5A5A);
        wr16(7'h29, 16'h00F6);
        check("R7 state cleared", fstate, 0);
        rd16(7'h28, v); check("R7 scratch cleared", v, 0);
        rd32(7'h04, w); check("R7 mask cleared", w, 0);
        rd16(7'h29, v); check("R7 key reads zero", v, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_id_scratch();
        t_ctrl();
        t_abandon();
        t_idle_and_collide();
        t_cmd();
        t_events();
        t_misc();
        t_swrst();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule